// File: doc/BRIEF.md
# Timer and Event Down-Counter

A 14-bit down-counter that either measures time or counts external events. In timer mode it steps down once for every cycle in which a one-cycle tick enable is high; the enable stands in for a prescaler driven from the system clock. In event mode it steps down once for every rising edge seen on an external event pin. The pin is first passed through a two-flop synchronizer.

Software writes a start value through a write port. The write takes effect at once: both the stored start value and the live count are loaded. When the count would reach zero, the block reloads the start value instead and sets a sticky interrupt request. The request stays high until a clear input is pulsed. The live count can be read at any time, so an elapsed time is the difference of two readings. A start value of 1 makes every qualifying step raise the request, which turns the event pin into an edge-triggered interrupt source. A start value of 0 stops all counting.

Top module: `evt_decrementer`

## Requirements
- R1: After reset, count_o is 0 and irq_o is 0.
- R2: A cycle with start_we_i high loads start_val_i into both the start value and the count. count_o shows the new value after that clock edge, and the write wins over any step in the same cycle.
- R3: In timer mode (mode_evt_i = 0), the count drops by exactly 1 at each clock edge where tick_i is high, and holds otherwise.
- R4: A step taken while the count is 1 loads the start value back into the count instead of producing 0, and sets irq_o at the same clock edge.
- R5: irq_o stays high until a cycle with irq_clr_i high and no new reload in that cycle. If a reload and a clear arrive together, irq_o stays high.
- R6: In event mode (mode_evt_i = 1), each 0-to-1 transition on evt_i lowers the count by one, three clock edges after the first edge that samples the pin high. A pin held high counts only once.
- R7: With a start value of 1 in event mode, every rising edge on evt_i sets irq_o, and count_o stays at 1.
- R8: While the start value is 0, no step changes the count and irq_o is never set.
- R9: The unselected source has no effect: tick_i is ignored in event mode, and edges on evt_i are ignored in timer mode.
- R10: The full 14-bit range is usable. After loading 16383 and applying N ticks with N below 16383, count_o reads 16383 − N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_evt_i | input | 1 | 0 = timer mode (tick_i), 1 = event mode (evt_i edges) |
| tick_i | input | 1 | One-cycle step enable used in timer mode |
| start_we_i | input | 1 | Write strobe for the start value |
| start_val_i | input | 14 | Start value to load |
| evt_i | input | 1 | Asynchronous external event pin |
| irq_clr_i | input | 1 | Clears the interrupt request |
| count_o | output | 14 | Live count |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The hardest situation to reach is a reload that lands in the same cycle as a clear pulse, or as a new start-value write. This is hardest in event mode, where a step arrives three edges after the pin moves. Directed cases fix the event latency and the behaviour at start values 1 and 0. A long random phase then uses small start values, dense ticks and pin toggles, and frequent clear and write strobes, so these collisions occur many times. Every cycle is compared against a bench model built from the requirements.

// File: rtl/evt_dec_pkg.sv
package evt_dec_pkg;
  typedef enum logic {
    SRC_TICK  = 1'b0,
    SRC_EVENT = 1'b1
  } step_src_e;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  // STAGES sync flops plus one history flop
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/evt_dec_core.sv
module evt_dec_core #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dec_en_o,
  output logic             reload_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] start_q, cnt_q;
  logic             armed;

  assign armed    = (start_q != '0);
  assign dec_en_o = step_i & armed & ~load_i;
  // reaching zero is replaced by a reload
  assign reload_o = dec_en_o & (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      start_q <= load_val_i;
      cnt_q   <= load_val_i;
    end else if (reload_o) begin
      cnt_q   <= start_q;
    end else if (dec_en_o) begin
      cnt_q   <= cnt_q - ONE;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/evt_irq_flag.sv
module evt_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evt_decrementer.sv
module evt_decrementer #(
  parameter int unsigned CNT_W       = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_evt_i,
  input  logic             tick_i,
  input  logic             start_we_i,
  input  logic [CNT_W-1:0] start_val_i,
  input  logic             evt_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  import evt_dec_pkg::*;

  step_src_e src;
  logic      evt_rise, step, dec_en_w, reload_w;

  assign src = step_src_e'(mode_evt_i);

  evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (evt_i),
    .rise_o (evt_rise)
  );

  assign step = (src == SRC_EVENT) ? evt_rise : tick_i;

  evt_dec_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_we_i),
    .load_val_i (start_val_i),
    .step_i     (step),
    .count_o    (count_o),
    .dec_en_o   (dec_en_w),
    .reload_o   (reload_w)
  );

  evt_irq_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (reload_w),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/evt_dec_checker.sv
module evt_dec_checker #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_we_i,
  input logic [CNT_W-1:0] start_val_i,
  input logic             irq_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             dec_en_i,
  input logic             reload_i
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_we_i |=> count_o == $past(start_val_i));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_en_i && !reload_i) |=> count_o == $past(count_o) - 1'b1);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_we_i && !dec_en_i) |=> $stable(count_o));

  p_reload_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> irq_o);

  p_irq_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  p_irq_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !reload_i) |=> !irq_o);

  p_irq_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(reload_i));
endmodule

bind evt_decrementer evt_dec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_we_i  (start_we_i),
  .start_val_i (start_val_i),
  .irq_clr_i   (irq_clr_i),
  .count_o     (count_o),
  .irq_o       (irq_o),
  .dec_en_i    (dec_en_w),
  .reload_i    (reload_w)
);

// File: tb/tb_evt_decrementer.sv
module tb_evt_decrementer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode = 1'b0, tick = 1'b0, we = 1'b0, pin = 1'b0, clr = 1'b0;
  logic [W-1:0] val = '0;
  logic [W-1:0] count;
  logic         irq;

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_decrementer dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_evt_i(mode), .tick_i(tick),
    .start_we_i(we), .start_val_i(val), .evt_i(pin), .irq_clr_i(clr),
    .count_o(count), .irq_o(irq)
  );

  // Reference model from the requirements (two sync flops + history, R6)
  logic [W-1:0] m_start, m_cnt;
  logic         m_irq, p1, p2, p3;

  function automatic logic m_step(logic md, logic tk, logic rise);
    return md ? rise : tk;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = '0; m_cnt = '0; m_irq = 1'b0; p1 = 0; p2 = 0; p3 = 0;
    end else begin
      logic rise, set;
      rise = p2 & ~p3;
      set  = 1'b0;
      if (we) begin
        m_start = val; m_cnt = val;
      end else if (m_start != 0 && m_step(mode, tick, rise)) begin
        if (m_cnt <= 1) begin m_cnt = m_start; set = 1'b1; end
        else m_cnt = m_cnt - 1'b1;
      end
      if (set) m_irq = 1'b1;
      else if (clr) m_irq = 1'b0;
      p3 = p2; p2 = p1; p1 = pin;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3/R4/R5/R6 random count", {18'd0, count}, {18'd0, m_cnt});
      chk("R4/R5 random irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr(logic [W-1:0] v);
    we = 1'b1; val = v; cyc(); we = 1'b0;
  endtask

  task automatic clear_irq();
    clr = 1'b1; cyc(); clr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    cyc(2);
    chk("R1 reset count", {18'd0, count}, 0);
    chk("R1 reset irq", {31'd0, irq}, 0);
    rst_n = 1'b1;
    cyc();

    // timer mode
    mode = 1'b0;
    tick = 1'b1; wr(5); tick = 1'b0;
    chk("R2 load wins over tick", {18'd0, count}, 5);
    cyc(3);
    chk("R3 hold without tick", {18'd0, count}, 5);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R3 single step", {18'd0, count}, 4);
    tick = 1'b1; cyc(3); tick = 1'b0;
    chk("R3 count at 1", {18'd0, count}, 1);
    chk("R4 no irq before reload", {31'd0, irq}, 0);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R4 reload value", {18'd0, count}, 5);
    chk("R4 irq raised", {31'd0, irq}, 1);
    cyc(4);
    chk("R5 irq sticky", {31'd0, irq}, 1);
    clear_irq();
    chk("R5 irq cleared", {31'd0, irq}, 0);
    for (int i = 0; i < 6; i++) begin pin = ~pin; cyc(); end
    pin = 1'b0; cyc(3);
    chk("R9 pin ignored in timer mode", {18'd0, count}, 5);

    // event mode
    mode = 1'b1;
    wr(3);
    pin = 1'b1; cyc(2);
    chk("R6 no step before latency", {18'd0, count}, 3);
    cyc();
    chk("R6 step after three edges", {18'd0, count}, 2);
    cyc(5);
    chk("R6 held level counts once", {18'd0, count}, 2);
    tick = 1'b1; cyc(4); tick = 1'b0;
    chk("R9 tick ignored in event mode", {18'd0, count}, 2);
    pin = 1'b0; cyc(3);

    wr(1);
    for (int k = 0; k < 3; k++) begin
      clear_irq();
      pin = 1'b1; cyc(3);
      chk("R7 edge interrupt", {31'd0, irq}, 1);
      chk("R7 count stays 1", {18'd0, count}, 1);
      pin = 1'b0; cyc(2);
    end
    clear_irq();

    // start value 0
    wr(0);
    mode = 1'b0; tick = 1'b1; cyc(6);
    mode = 1'b1; tick = 1'b0;
    for (int i = 0; i < 6; i++) begin pin = ~pin; cyc(); end
    pin = 1'b0; cyc(3);
    chk("R8 disabled count", {18'd0, count}, 0);
    chk("R8 disabled no irq", {31'd0, irq}, 0);

    // full range / elapsed time
    mode = 1'b0;
    wr(14'd16383);
    tick = 1'b1; cyc(100); tick = 1'b0;
    chk("R10 elapsed from max", {18'd0, count}, 16283);
    tick = 1'b1; cyc(37); tick = 1'b0;
    chk("R10 second reading", {18'd0, count}, 16246);

    // random phase, model-checked every cycle
    cmp_en = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 200) == 0) mode = ~mode;
      tick = ($urandom % 3) != 0;
      pin  = ($urandom % 3) == 0 ? ~pin : pin;
      clr  = ($urandom % 7) == 0;
      we   = ($urandom % 40) == 0;
      val  = W'($urandom % 6);
      cyc();
    end
    we = 1'b0; clr = 1'b0; tick = 1'b0;
    cyc();
    cmp_en = 1'b0;
    summary();
  end
endmodule